// File: doc/BRIEF.md
# Compressed-Block Pointer Lookup with Index Cache

This block sits in the instruction-cache miss path of a processor that runs compressed code. Given the native byte address of a missing instruction, it returns the byte address in main memory where the compressed block holding that instruction begins. The pointers live in a table in main memory. Each table line holds four consecutive 32-bit pointers, one for each 64-byte native block. A small fully associative cache of such lines keeps most lookups off the memory bus.

A miss request is accepted through a valid/ready handshake. The block splits the address into three fields: a byte offset, which is ignored; a two-bit entry select; and a tag, which also serves as the table line number. On a tag match the pointer is returned on the next cycle. On a mismatch the block issues a single line read at `tbl_base + tag*16`, returns the selected entry when the line arrives, and installs the line in the cache. Empty slots are filled first. Once every slot is valid, a round-robin pointer chooses the victim. A flush input invalidates every line. Only one miss is handled at a time.

Top module: `idx_ptr_cache`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `resp_valid` and `rd_req` are 0, and the cache holds no valid line, so the first request misses.
- R2: The request address is split into three fields. Bits [5:0] are a byte offset and have no effect on the result. Bits [7:6] pick the entry within a table line. Bits [31:8] form the tag, which is also the table line number.
- R3: A request accepted while its tag is cached gives `resp_valid` high for one cycle, on the cycle right after acceptance. `resp_ptr` then equals the selected entry of the cached line, and no memory read is issued.
- R4: A request accepted while its tag is not cached raises `rd_req` on the next cycle with `rd_addr = tbl_base + tag*16`. `req_ready` stays low until `rd_valid` is seen. `resp_valid` rises on the cycle after `rd_valid`, and `resp_ptr` then equals `rd_data[32*sel+31 : 32*sel]`.
- R5: A fetched line is installed in the cache. Later requests whose tag matches it hit, whatever their entry select or offset.
- R6: On a fill, the lowest-numbered invalid slot is chosen. If every slot is valid, the slot named by a round-robin pointer is replaced, and the pointer then advances by one, wrapping around. The pointer does not move on fills into invalid slots, and a flush does not move it.
- R7: `flush` clears every valid bit. A request accepted in the same cycle as `flush` is treated as a miss, even if its tag was cached.
- R8: If `flush` is high on any cycle while a line read is outstanding, including the `rd_valid` cycle, the response is still delivered but the line is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached lines |
| tbl_base | input | 32 | Byte address of the pointer table |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Native miss byte address |
| resp_valid | output | 1 | One-cycle pulse: pointer valid |
| resp_ptr | output | 32 | Compressed block byte address |
| rd_req | output | 1 | Table line read pending, held until `rd_valid` |
| rd_addr | output | 32 | Byte address of the table line |
| rd_valid | input | 1 | Table line data present |
| rd_data | input | 128 | Four entries, entry k at bits [32k+31:32k] |

## Verification
A flush can land in the same cycle as a lookup, and it can also land while a fill is outstanding or on the very cycle the fill data returns. In both cases the invalidation must win.

The bench provokes the first case by driving `flush` together with a request whose tag is known to be cached. It provokes the second by pulsing `flush` one cycle after a miss is accepted, with read latencies as low as zero, so that the pulse sometimes coincides with `rd_valid`.

A reference model of tags, valid bits and the round-robin pointer predicts the outcome of each request. Each outcome is judged by the response latency, by whether `rd_req` appears, by the line address, and by the returned pointer.

// File: rtl/idxc_pkg.sv
package idxc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } idxc_state_t;
endpackage

// File: rtl/idx_tag_store.sv
module idx_tag_store #(
  parameter int LINES = 64,
  parameter int TAG_W = 24,
  parameter int WAY_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAY_W-1:0] vict_way
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] hit_vec;
  logic [WAY_W-1:0] rr_q;
  logic [WAY_W-1:0] free_way;
  logic             any_free;

  // one comparator per slot
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < LINES; i++)
      if (hit_vec[i]) hit_way = WAY_W'(i);
  end

  // lowest free slot wins
  always_comb begin
    free_way = '0;
    any_free = 1'b0;
    for (int i = LINES - 1; i >= 0; i--)
      if (!vld_q[i]) begin
        free_way = WAY_W'(i);
        any_free = 1'b1;
      end
  end

  assign vict_way = any_free ? free_way : rr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[vict_way] <= 1'b1;
      if (!any_free) rr_q <= rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[vict_way] <= wr_tag;
  end

  // at most one slot may ever match a tag
  p_single_match_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // a flush leaves nothing valid
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_q == '0));

  // a write installs the requested tag so it matches next
  p_install_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> vld_q[$past(vict_way)]);
endmodule

// File: rtl/idx_line_ram.sv
module idx_line_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 128
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/idx_ptr_cache.sv
module idx_ptr_cache #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 6,
  parameter int SEL_W  = 2,
  parameter int LINES  = 64,
  parameter int ENT_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic [ADDR_W-1:0]            tbl_base,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         resp_valid,
  output logic [ENT_W-1:0]             resp_ptr,
  output logic                         rd_req,
  output logic [ADDR_W-1:0]            rd_addr,
  input  logic                         rd_valid,
  input  logic [(1<<SEL_W)*ENT_W-1:0]  rd_data
);
  import idxc_pkg::*;

  localparam int ENTS    = 1 << SEL_W;
  localparam int TAG_W   = ADDR_W - OFFS_W - SEL_W;
  localparam int WAY_W   = $clog2(LINES);
  localparam int LINE_W  = ENTS * ENT_W;
  localparam int LN_SH   = SEL_W + $clog2(ENT_W / 8);

  idxc_state_t      st_q;
  logic [SEL_W-1:0] sel_q;
  logic [TAG_W-1:0] pend_tag_q;
  logic             cancel_q;
  logic             use_fill_q;
  logic [LINE_W-1:0] fill_q;
  logic [LINE_W-1:0] ram_q;
  logic [LINE_W-1:0] src_line;

  logic [TAG_W-1:0] lk_tag;
  logic [SEL_W-1:0] lk_sel;
  logic             hit, hit_eff, accept, wr_en;
  logic [WAY_W-1:0] hit_way, vict_way;

  assign lk_tag    = req_addr[ADDR_W-1 -: TAG_W];
  assign lk_sel    = req_addr[OFFS_W +: SEL_W];
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit_eff   = hit && !flush;
  assign wr_en     = (st_q == ST_FILL) && rd_valid && !cancel_q && !flush;

  idx_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_tags (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .lk_tag   (lk_tag),
    .wr_en    (wr_en),
    .wr_tag   (pend_tag_q),
    .hit      (hit),
    .hit_way  (hit_way),
    .vict_way (vict_way)
  );

  idx_line_ram #(.DEPTH(LINES), .AW(WAY_W), .DW(LINE_W)) i_lines (
    .clk   (clk),
    .we    (wr_en),
    .waddr (vict_way),
    .wdata (rd_data),
    .re    (accept && hit_eff),
    .raddr (hit_way),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      resp_valid <= 1'b0;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      sel_q      <= '0;
      pend_tag_q <= '0;
      cancel_q   <= 1'b0;
      use_fill_q <= 1'b0;
      fill_q     <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            sel_q      <= lk_sel;
            pend_tag_q <= lk_tag;
            if (hit_eff) begin
              resp_valid <= 1'b1;
              use_fill_q <= 1'b0;
            end else begin
              st_q     <= ST_FILL;
              rd_req   <= 1'b1;
              rd_addr  <= tbl_base + (ADDR_W'(lk_tag) << LN_SH);
              cancel_q <= 1'b0;
            end
          end
        end
        ST_FILL: begin
          if (flush) cancel_q <= 1'b1;
          if (rd_valid) begin
            st_q       <= ST_IDLE;
            rd_req     <= 1'b0;
            fill_q     <= rd_data;
            use_fill_q <= 1'b1;
            resp_valid <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign src_line = use_fill_q ? fill_q : ram_q;
  assign resp_ptr = src_line[sel_q*ENT_W +: ENT_W];

  p_hit_next_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && hit_eff) |=> (resp_valid && !rd_req));

  p_miss_read_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit_eff) |=> (rd_req && !req_ready && !resp_valid));

  p_fill_done_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid) |=> (resp_valid && !rd_req && req_ready));

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  p_no_install_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid && flush) |-> !wr_en);
endmodule

// File: tb/test_idx_ptr_cache.sv
`timescale 1ns/1ps
module test_idx_ptr_cache;
  localparam int NL = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         flush = 1'b0;
  logic [31:0]  tbl_base = 32'h0040_0000;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic         resp_valid;
  logic [31:0]  resp_ptr;
  logic         rd_req;
  logic [31:0]  rd_addr;
  logic         rd_valid = 1'b0;
  logic [127:0] rd_data = '0;

  int errs = 0, checks = 0, lat = 2, cnt = 0;
  bit done = 0;

  logic [23:0] mtag [NL];
  bit          mval [NL];
  int          mrr = 0;

  always #2 clk = ~clk;

  idx_ptr_cache i_idx_ptr_cache (
    .clk(clk), .rst(rst), .flush(flush), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_ptr(resp_ptr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [31:0] ent_fn(input logic [31:0] la, input int k);
    return (la * 32'h0000_9E37) ^ (32'h1111_0000 * (k + 1)) ^ 32'h0000_0A5C;
  endfunction

  function automatic logic [127:0] line_fn(input logic [31:0] la);
    logic [127:0] v;
    for (int k = 0; k < 4; k++) v[32*k +: 32] = ent_fn(la, k);
    return v;
  endfunction

  // table memory: answers after lat extra cycles
  always @(negedge clk) begin
    rd_valid <= 1'b0;
    if (rd_req && !rd_valid) begin
      if (cnt >= lat) begin
        rd_valid <= 1'b1;
        rd_data  <= line_fn(rd_addr);
        cnt      <= 0;
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int mlook(input logic [23:0] t);
    for (int i = 0; i < NL; i++) if (mval[i] && mtag[i] == t) return i;
    return -1;
  endfunction

  task automatic mflush();
    for (int i = 0; i < NL; i++) mval[i] = 0;
  endtask

  task automatic minstall(input logic [23:0] t);
    int v = -1;
    for (int i = NL - 1; i >= 0; i--) if (!mval[i]) v = i;
    if (v < 0) begin
      v = mrr;
      mrr = (mrr + 1) % NL;
    end
    mval[v] = 1;
    mtag[v] = t;
  endtask

  task automatic do_req(input logic [23:0] t, input logic [1:0] s, input logic [5:0] o,
                        input bit fl_with, input bit fl_during, input string rq);
    bit eh;
    int n;
    logic [31:0] la;
    la = tbl_base + {4'd0, t, 4'd0};
    eh = (mlook(t) >= 0) && !fl_with;
    if (fl_with) mflush();
    @(negedge clk);
    req_valid = 1'b1; req_addr = {t, s, o}; flush = fl_with;
    @(negedge clk);
    req_valid = 1'b0; flush = 1'b0; n = 1;
    if (eh) chk(rd_req == 1'b0, rq, "hit issued read", 32'(rd_req), 32'd0);
    else begin
      chk(rd_req == 1'b1, rq, "miss read request", 32'(rd_req), 32'd1);
      chk(rd_addr == la, rq, "line address", rd_addr, la);
      chk(req_ready == 1'b0, rq, "ready during fill", 32'(req_ready), 32'd0);
    end
    if (fl_during && !eh) begin
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0; n = 2;
    end
    while (!resp_valid && n < 100) begin
      @(negedge clk); n++;
    end
    chk(n == (eh ? 1 : lat + 2), rq, "response latency", 32'(n), 32'(eh ? 1 : lat + 2));
    chk(resp_ptr == ent_fn(la, s), rq, "pointer", resp_ptr, ent_fn(la, s));
    if (!eh) begin
      if (fl_during) mflush();
      else minstall(t);
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] pool [80];
    void'($urandom(32'd20240611));
    for (int i = 0; i < 80; i++) pool[i] = 24'(i * 7 + 3);
    mflush();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'd1);
    chk(resp_valid == 1'b0, "R1", "resp_valid", 32'(resp_valid), 32'd0);
    chk(rd_req == 1'b0, "R1", "rd_req", 32'(rd_req), 32'd0);
    lat = 2;
    do_req(24'h00ABCD, 2'd1, 6'd5, 0, 0, "R1");     // empty cache misses
    do_req(24'h00ABCD, 2'd3, 6'd63, 0, 0, "R2");    // other sel/offset hits
    do_req(24'h00ABCD, 2'd0, 6'd0, 0, 0, "R5");
    do_req(24'h00ABCD, 2'd2, 6'd17, 0, 0, "R3");
    do_req(24'h00ABCD, 2'd2, 6'd17, 1, 0, "R7");    // flush with request
    do_req(24'h00ABCD, 2'd1, 6'd1, 0, 0, "R7");
    lat = 3;
    do_req(24'h123456, 2'd0, 6'd9, 0, 1, "R8");     // flush mid fill
    do_req(24'h123456, 2'd1, 6'd9, 0, 0, "R8");
    lat = 0;
    do_req(24'h0F0F0F, 2'd2, 6'd2, 0, 1, "R8");     // flush on rd_valid cycle
    do_req(24'h0F0F0F, 2'd3, 6'd2, 0, 0, "R8");
    // R6 fill every slot, then round robin
    lat = 1;
    do_req(pool[0], 2'd0, 6'd0, 1, 0, "R6");
    for (int i = 1; i < 66; i++) do_req(pool[i], 2'(i), 6'(i), 0, 0, "R6");
    do_req(pool[0], 2'd1, 6'd0, 0, 0, "R6");
    do_req(pool[1], 2'd1, 6'd0, 0, 0, "R6");
    do_req(pool[5], 2'd2, 6'd0, 0, 0, "R6");
    // random mix
    for (int i = 0; i < 500; i++) begin
      int r = $urandom_range(0, 99);
      lat = $urandom_range(0, 3);
      do_req(pool[$urandom_range(0, 79)], 2'($urandom_range(0, 3)), 6'($urandom_range(0, 63)),
             r < 3, (r >= 3 && r < 6), "R5");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule